// File: doc/BRIEF.md
# Card Slot Status Change Interrupt

This block is the per-slot status and change-interrupt logic of a removable-card socket controller. It synchronises seven raw socket pins: two card-detect lines, two battery-voltage-detect lines, write-protect, ready/busy and power-good. It shows their live state in a status register and turns transitions of card presence and battery health into sticky change flags. When a flag is set and its enable bit is on, it raises an interrupt.

Host software reaches the registers through an index/data pair. It first writes an index through the index strobe. A data read or data write then acts on the register that the index selects. The two upper index bits select the slot window: they must equal the device and slot numbers given as parameters. This lets several slots share one host port.

A small two-state access machine answers reads. In `HP_IDLE` the machine waits. A data read that hits the window moves it to `HP_RESP` and latches the read data. In `HP_RESP` the response-valid output is high for that cycle. A further hitting read keeps the machine in `HP_RESP` (back-to-back). Any other cycle returns it to `HP_IDLE`.

Top module: `socket_change_irq`

## Requirements
- R1: After reset the change flags and the enables are clear, and the irq output is low. The pin levels present during reset are taken as the baseline, so steady pins report no change.
- R2: Offset 0x0 reads the parameter ID_CODE, which defaults to 0x82 (upper nibble 0x8). Writes to this offset have no effect.
- R3: Offset 0x1 reads the live pins after the synchroniser. Bit 6 is power-good, bit 5 is ready, bit 4 is write-protect, bits 3:2 are the two detect lines and bits 1:0 are the battery code. Bit 7 reads 0.
- R4: A card counts as present only when both detect lines are high. Every change of presence sets change bit 3. A detect-line change that leaves presence unchanged sets nothing.
- R5: The battery code is good when it is 11, warning when it is 01, and dead when it is 00 or 10. Each change into or out of the warning state sets change bit 1. Each change into or out of the dead state sets change bit 0.
- R6: Change flags are sticky at offset 0x4; its bits 7:4 and 2 read 0. A read there returns the flags and clears them in the same cycle. A data write to this offset is ignored.
- R7: A change that arrives in the same cycle as the clearing read is kept and stays set after that read.
- R8: Offset 0x5 is read/write. Bits 7:4 form the interrupt number, which drives irq_num. Bits 3, 1 and 0 enable change bits 3, 1 and 0. Bit 2 reads 0.
- R9: irq is high exactly while some change flag and its enable are both set. It drops in the cycle after a clearing read, unless R7 applies.
- R10: Index bits 7:6 must equal {DEV_NUM, SLOT_NUM} (default 0x40 to 0x7F). Data accesses outside this window get no response and have no effect. Unused offsets inside the window read 0.
- R11: host_rd_valid is high for one cycle after each data read strobe that hits the window, and host_rdata holds the value then. Back-to-back reads give back-to-back responses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_idx_wr | input | 1 | Load host_wdata into the index register |
| host_dat_wr | input | 1 | Write host_wdata to the selected register |
| host_dat_rd | input | 1 | Read the selected register |
| host_wdata | input | 8 | Index or write data |
| host_rdata | output | 8 | Read data, valid with host_rd_valid |
| host_rd_valid | output | 1 | Read response strobe |
| pin_det | input | 2 | Card-detect lines, high = contact |
| pin_bvd | input | 2 | Battery-voltage-detect code |
| pin_wp | input | 1 | Write-protect |
| pin_rdy | input | 1 | Ready/busy |
| pin_pwr | input | 1 | Power-good |
| irq | output | 1 | Status change interrupt |
| irq_num | output | 4 | Selected interrupt number |

## Verification
A wrong baseline or change detector shows up as an irq edge or a non-zero change read three cycles after a pin moves. These faults include a presence rule that accepts one detect line, or a battery state mapped to the wrong flag. A clear that loses a simultaneous event appears on the very next read of offset 0x4, which returns 0 instead of the flag. A decode fault appears as a response outside the slot window, or as a missing response inside it, one cycle after the read strobe.

// File: rtl/sock_pkg.sv
package sock_pkg;
    localparam int DATA_W = 8;
    localparam int OFF_W  = 6;

    // Pin bundle laid out so that it maps onto status bits 6:0
    typedef struct packed {
        logic       pwr;
        logic       rdy;
        logic       wp;
        logic [1:0] det;
        logic [1:0] bvd;
    } pins_t;

    localparam int PIN_W = $bits(pins_t);

    localparam logic [OFF_W-1:0] OFF_ID   = 6'h00;
    localparam logic [OFF_W-1:0] OFF_STAT = 6'h01;
    localparam logic [OFF_W-1:0] OFF_CHG  = 6'h04;
    localparam logic [OFF_W-1:0] OFF_CFG  = 6'h05;

    // Flag vector order: {presence, warning, dead}
    localparam int FL_DET  = 2;
    localparam int FL_WARN = 1;
    localparam int FL_DEAD = 0;
    localparam int FL_N    = 3;

    typedef enum logic {
        HP_IDLE,
        HP_RESP
    } host_state_t;
endpackage

// File: rtl/sock_pin_sync.sv
module sock_pin_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);
    logic [STAGES-1:0][W-1:0] chain;

    // During reset every stage loads the raw pins so the baseline is current
    always_ff @(posedge clk) begin
        chain[0] <= raw;
        for (int s = 1; s < STAGES; s++) begin
            chain[s] <= rst_n ? chain[s-1] : raw;
        end
    end

    assign synced = chain[STAGES-1];
endmodule

// File: rtl/sock_change_track.sv
module sock_change_track
    import sock_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  pins_t           cur,
    input  logic            clr,
    output logic [FL_N-1:0] evt,
    output logic [FL_N-1:0] flags
);
    logic [FL_N-1:0] now_v;
    logic [FL_N-1:0] prev_q;

    always_comb begin
        now_v          = '0;
        now_v[FL_DET]  = &cur.det;
        now_v[FL_WARN] = (cur.bvd == 2'b01);
        now_v[FL_DEAD] = ~cur.bvd[0];
    end

    assign evt = now_v ^ prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= now_v;
            flags  <= '0;
        end else begin
            prev_q <= now_v;
            // a new event wins over a clear in the same cycle
            flags  <= (clr ? '0 : flags) | evt;
        end
    end
endmodule

// File: rtl/sock_host_port.sv
module sock_host_port
    import sock_pkg::*;
#(
    parameter logic [1:0]        WIN_TAG = 2'b01,
    parameter logic [DATA_W-1:0] ID_CODE = 8'h82
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_wr,
    input  logic              dat_wr,
    input  logic              dat_rd,
    input  logic [DATA_W-1:0] wdata,
    input  pins_t             stat,
    input  logic [FL_N-1:0]   flags,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_valid,
    output logic              rd_accept,
    output logic              chg_clr,
    output logic [3:0]        num,
    output logic [FL_N-1:0]   en
);
    host_state_t       state_q, state_d;
    logic [DATA_W-1:0] idx_q;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;
    logic              hit;
    logic [OFF_W-1:0]  off;

    assign hit       = (idx_q[DATA_W-1 -: 2] == WIN_TAG);
    assign off       = idx_q[OFF_W-1:0];
    assign rd_accept = dat_rd && hit;
    assign chg_clr   = rd_accept && (off == OFF_CHG);

    always_comb begin
        case (off)
            OFF_ID:   rd_mux = ID_CODE;
            OFF_STAT: rd_mux = {1'b0, stat};
            OFF_CHG:  rd_mux = {4'b0, flags[FL_DET], 1'b0, flags[FL_WARN], flags[FL_DEAD]};
            OFF_CFG:  rd_mux = {num, en[FL_DET], 1'b0, en[FL_WARN], en[FL_DEAD]};
            default:  rd_mux = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HP_IDLE: if (rd_accept)  state_d = HP_RESP;
            HP_RESP: if (!rd_accept) state_d = HP_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rd_valid = (state_q == HP_RESP);
        rdata    = rdata_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            rdata_q <= '0;
            num     <= '0;
            en      <= '0;
        end else begin
            if (idx_wr) idx_q <= wdata;
            if (rd_accept) rdata_q <= rd_mux;
            if (dat_wr && hit && off == OFF_CFG) begin
                num          <= wdata[7:4];
                en[FL_DET]   <= wdata[3];
                en[FL_WARN]  <= wdata[1];
                en[FL_DEAD]  <= wdata[0];
            end
        end
    end
endmodule

// File: rtl/socket_change_irq.sv
module socket_change_irq
    import sock_pkg::*;
#(
    parameter int               DEV_NUM     = 0,
    parameter int               SLOT_NUM    = 1,
    parameter logic [7:0]       ID_CODE     = 8'h82,
    parameter int               SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_idx_wr,
    input  logic       host_dat_wr,
    input  logic       host_dat_rd,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       host_rd_valid,
    input  logic [1:0] pin_det,
    input  logic [1:0] pin_bvd,
    input  logic       pin_wp,
    input  logic       pin_rdy,
    input  logic       pin_pwr,
    output logic       irq,
    output logic [3:0] irq_num
);
    localparam logic [1:0] WIN_TAG = {DEV_NUM[0], SLOT_NUM[0]};

    logic [PIN_W-1:0] raw_pins;
    logic [PIN_W-1:0] sync_pins;
    pins_t            cur;
    logic [FL_N-1:0]  chg_evt;
    logic [FL_N-1:0]  chg_flags;
    logic [FL_N-1:0]  chg_en;
    logic             chg_clr;
    logic             rd_accept;

    assign raw_pins = {pin_pwr, pin_rdy, pin_wp, pin_det, pin_bvd};
    assign cur      = pins_t'(sync_pins);

    sock_pin_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (raw_pins),
        .synced (sync_pins)
    );

    sock_change_track u_track (
        .clk   (clk),
        .rst_n (rst_n),
        .cur   (cur),
        .clr   (chg_clr),
        .evt   (chg_evt),
        .flags (chg_flags)
    );

    sock_host_port #(.WIN_TAG(WIN_TAG), .ID_CODE(ID_CODE)) u_host (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_wr    (host_idx_wr),
        .dat_wr    (host_dat_wr),
        .dat_rd    (host_dat_rd),
        .wdata     (host_wdata),
        .stat      (cur),
        .flags     (chg_flags),
        .rdata     (host_rdata),
        .rd_valid  (host_rd_valid),
        .rd_accept (rd_accept),
        .chg_clr   (chg_clr),
        .num       (irq_num),
        .en        (chg_en)
    );

    assign irq = |(chg_flags & chg_en);
endmodule

// File: rtl/socket_change_irq_chk.sv
module socket_change_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] evt,
    input logic [2:0] flags,
    input logic       clr,
    input logic       rd_accept,
    input logic       rd_valid,
    input logic       irq
);
    // R1: clean state right after reset
    assert_reset_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (flags == 3'b000 && !irq));

    // R4: a presence event is recorded
    assert_det_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        evt[2] |=> flags[2]);

    // R6: flags hold without event or clear
    assert_flags_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && evt == 3'b000) |=> $stable(flags));

    // R7: a simultaneous event survives the clear
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && evt[0]) |=> flags[0]);

    // R9: interrupt drops after a clearing read with no new event
    assert_irq_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && evt == 3'b000) |=> !irq);

    // R11: a response only follows an accepted read
    assert_resp_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_accept));
endmodule

bind socket_change_irq socket_change_irq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (chg_evt),
    .flags     (chg_flags),
    .clr       (chg_clr),
    .rd_accept (rd_accept),
    .rd_valid  (host_rd_valid),
    .irq       (irq)
);

// File: tb/tb_socket_change_irq.sv
`timescale 1ns/1ps
module tb_socket_change_irq;
    localparam logic [7:0] BASE = 8'h40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       idx_wr = 1'b0, dat_wr = 1'b0, dat_rd = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rd_valid;
    logic [1:0] det = 2'b11, bvd = 2'b11;
    logic       wp = 1'b0, rdy = 1'b1, pwr = 1'b1;
    logic       irq;
    logic [3:0] irq_num;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;
    exp_t exp_q[$];
    exp_t cur_e;

    always #4 clk = ~clk;

    socket_change_irq dut (
        .clk(clk), .rst_n(rst_n),
        .host_idx_wr(idx_wr), .host_dat_wr(dat_wr), .host_dat_rd(dat_rd),
        .host_wdata(wdata), .host_rdata(rdata), .host_rd_valid(rd_valid),
        .pin_det(det), .pin_bvd(bvd), .pin_wp(wp), .pin_rdy(rdy), .pin_pwr(pwr),
        .irq(irq), .irq_num(irq_num)
    );

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on each response
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                n_checks++;
                n_fail++;
                $display("FAIL R10/R11 unexpected response: actual=%h expected=none", rdata);
            end else begin
                cur_e = exp_q.pop_front();
                check8(cur_e.tag, rdata, cur_e.val);
            end
        end
    end

    task automatic set_index(input logic [7:0] i);
        idx_wr = 1'b1; wdata = i;
        @(negedge clk);
        idx_wr = 1'b0;
    endtask

    task automatic rd_now(input logic [7:0] exp, input string tag);
        dat_rd = 1'b1;
        exp_q.push_back('{exp, tag});
        @(negedge clk);
        dat_rd = 1'b0;
    endtask

    task automatic rd(input logic [5:0] off, input logic [7:0] exp, input string tag);
        set_index(BASE | {2'b00, off});
        rd_now(exp, tag);
    endtask

    task automatic wr(input logic [5:0] off, input logic [7:0] val);
        set_index(BASE | {2'b00, off});
        dat_wr = 1'b1; wdata = val;
        @(negedge clk);
        dat_wr = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        settle();
        // R1 reset state
        check8("R1 irq after reset", {7'b0, irq}, 8'h00);
        rd(6'h04, 8'h00, "R1 no spurious change");
        rd(6'h05, 8'h00, "R1 enables clear");
        // R2 identification
        rd(6'h00, 8'h82, "R2 id");
        wr(6'h00, 8'h00);
        rd(6'h00, 8'h82, "R2 id read-only");
        // R3 live status
        rd(6'h01, 8'h6F, "R3 status");
        // R8 config
        wr(6'h05, 8'h5F);
        rd(6'h05, 8'h5B, "R8 config readback");
        check8("R8 irq_num", {4'b0, irq_num}, 8'h05);
        rd(6'h02, 8'h00, "R10 unused offset");
        // R4 removal
        det = 2'b10; settle();
        check8("R9 irq on removal", {7'b0, irq}, 8'h01);
        rd(6'h01, 8'h6B, "R3 status after removal");
        rd(6'h04, 8'h08, "R4 presence change");
        check8("R9 irq cleared", {7'b0, irq}, 8'h00);
        rd(6'h04, 8'h00, "R6 cleared on read");
        det = 2'b00; settle();
        rd(6'h04, 8'h00, "R4 no presence change");
        det = 2'b01; settle();
        rd(6'h04, 8'h00, "R4 one line only");
        det = 2'b11; settle();
        check8("R4 irq on insert", {7'b0, irq}, 8'h01);
        wr(6'h04, 8'h00);
        rd(6'h04, 8'h08, "R6 write ignored");
        // R10 window
        det = 2'b10; settle();
        set_index(8'h04);
        dat_rd = 1'b1;
        @(negedge clk);
        dat_rd = 1'b0;
        check8("R10 no response outside window", {7'b0, rd_valid}, 8'h00);
        rd(6'h04, 8'h08, "R10 flags untouched");
        // R5 battery
        bvd = 2'b01; settle();
        rd(6'h04, 8'h02, "R5 warning");
        bvd = 2'b00; settle();
        rd(6'h04, 8'h03, "R5 warning to dead");
        bvd = 2'b10; settle();
        rd(6'h04, 8'h00, "R5 dead to dead");
        bvd = 2'b11; settle();
        rd(6'h04, 8'h01, "R5 dead to good");
        // R9 masking
        wr(6'h05, 8'h08);
        check8("R8 irq_num zero", {4'b0, irq_num}, 8'h00);
        bvd = 2'b00; settle();
        check8("R9 masked flag", {7'b0, irq}, 8'h00);
        rd(6'h04, 8'h01, "R9 masked flag still recorded");
        bvd = 2'b11; settle();
        rd(6'h04, 8'h01, "R5 recovery");
        // R7 event coinciding with clear
        set_index(BASE | 8'h04);
        det = 2'b11;
        @(negedge clk);
        @(negedge clk);
        rd_now(8'h00, "R7 read at event edge");
        check8("R7 irq kept", {7'b0, irq}, 8'h01);
        rd(6'h04, 8'h08, "R7 flag kept");
        // R11 back-to-back
        set_index(BASE);
        dat_rd = 1'b1;
        exp_q.push_back('{8'h82, "R11 first"});
        @(negedge clk);
        exp_q.push_back('{8'h82, "R11 second"});
        @(negedge clk);
        dat_rd = 1'b0;
        @(negedge clk);
        check8("R11 single-cycle valid", {7'b0, rd_valid}, 8'h00);
        check8("R11 all responses seen", exp_q.size()[7:0], 8'h00);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R11 watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule